// File: doc/BRIEF.md
# Receive Byte Queue with Run-Time Depth Selection

This block buffers received bytes for a 16550-style serial port. Bytes come in from the receive source, which is the deserializer in normal operation or the transmit path in loopback. Host reads of the data register take them out in arrival order. A mode input sets the active capacity at run time. With the mode low, the block is a single holding register. With the mode high, it is a queue of up to 16 entries. Every change of mode empties the queue. A separate flush input also empties it and selects the full depth.

The block reports its occupancy, a not-empty flag and a full flag. The full flag is the backpressure signal that pauses the source. A write offered while full is refused, and the refusal is reported on a same-cycle overflow strobe, which the line-status logic can latch. The head byte is shown on the read data port at all times. When the queue is empty that port reads all ones.

Top module: `rxq_switchable_fifo`

## Requirements
- R1: After reset the occupancy is 0, `not_empty` and `full` are low, and the active depth is 1.
- R2: With `deep_sel` low and the block empty, one accepted write makes `full` high and occupancy 1. The stored byte is shown on `rd_data`.
- R3: With the depth at 16, up to 16 writes are accepted, and reads return the bytes in the order they were written.
- R4: In any cycle where `deep_sel` differs from the current mode, the next cycle shows occupancy 0. The depth becomes 1 for `deep_sel`=0 and 16 for `deep_sel`=1. A write or read offered in that cycle has no effect.
- R5: `flush` high empties the block and sets the depth to 16, whatever the mode. If a mode change happens in the same cycle, the depth follows the new mode. A write or read offered in that cycle has no effect.
- R6: A write offered while occupancy equals the active depth is refused. `ovf` is high in that same cycle and the stored contents are unchanged. Occupancy never exceeds the depth.
- R7: `full` is high exactly when occupancy equals the active depth. It goes low in the cycle after a read taken from a full block.
- R8: The read and write positions wrap modulo the active depth, so arrival order is kept across the wrap.
- R9: When the block is empty, `rd_data` is 0xFF and a read changes nothing.
- R10: A read and a write in the same cycle on a block that is neither empty nor full leave the occupancy unchanged. On an empty block only the write takes effect. On a full block only the read does, and the write raises `ovf`.
- R11: `not_empty` is high exactly when occupancy is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| deep_sel | input | 1 | Mode: 0 single holding register, 1 sixteen-entry queue |
| flush | input | 1 | Empty the block and select the full depth |
| wr_en | input | 1 | Write strobe from the receive source |
| wr_data | input | 8 | Byte to store |
| ovf | output | 1 | Write refused this cycle because the block is full |
| rd_en | input | 1 | Read strobe from a host data-register read |
| rd_data | output | 8 | Head byte, or 0xFF when empty |
| count | output | 5 | Occupancy |
| not_empty | output | 1 | Occupancy nonzero |
| full | output | 1 | Occupancy equals active depth (backpressure) |

## Verification
`rd_data` and `ovf` answer in the same cycle as the strobe that meets them. Occupancy, the flags and the new head byte change one clock edge after an accepted write, read, flush or mode change. The bench drives inputs on the falling edge and compares every output 1 ns later. At that point the outputs still reflect the state before the coming rising edge. The reference queue is updated only after that edge, so each compare is against the state the outputs should show in that cycle. Directed sequences cover both depths, the wrap, refusals, concurrent strobes, flushes and mode switches with data held. A pseudo-random phase mixes all of these.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Default geometry of the receive queue.
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_DEPTH  = 16;

    // Operating mode: single holding register or full-depth queue.
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DEEP   = 1'b1
    } rxq_mode_e;

    // Per-cycle decision from the control unit to the datapath.
    typedef struct packed {
        logic push;   // write accepted
        logic pop;    // read accepted
        logic clear;  // contents and positions cleared
    } rxq_op_t;

    // Map the mode select pin to the mode type.
    function automatic rxq_mode_e sel_to_mode(input logic sel);
        return sel ? MODE_DEEP : MODE_SINGLE;
    endfunction

endpackage

// File: rtl/rxq_ptr.sv
// Position counter that wraps at a run-time limit.
module rxq_ptr #(
    parameter int PTR_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] lim,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    logic             at_end;

    assign at_end = (CNT_W'(ptr_q) + CNT_W'(1)) >= lim;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else if (adv) begin
            ptr_d = at_end ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    // R8: a position always stays below the active depth
    a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(ptr_q) < lim);

    // R8: advancing from the last slot returns to slot 0
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && at_end) |=> (ptr_q == '0));

endmodule

// File: rtl/rxq_store.sv
// Byte storage: one register per slot, combinational read of the head slot.
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(i))) begin
                slot[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (raddr == PTR_W'(j)) begin
                rdata = slot[j];
            end
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
// Mode, active depth and occupancy; decides which strobes take effect.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deep_sel,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_en,
    output rxq_op_t          op,
    output logic             ovf,
    output logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] count,
    output logic             not_empty,
    output logic             full
);

    localparam logic [CNT_W-1:0] DEPTH_DEEP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_ONE  = CNT_W'(1);

    rxq_mode_e        mode_q;
    rxq_mode_e        mode_new;
    logic [CNT_W-1:0] depth_q;
    logic [CNT_W-1:0] count_q;
    logic             mode_chg;
    logic             is_full;
    logic             is_empty;

    assign mode_new = sel_to_mode(deep_sel);
    assign mode_chg = (mode_new != mode_q);
    assign is_full  = (count_q == depth_q);
    assign is_empty = (count_q == '0);

    always_comb begin
        op.clear = mode_chg | flush;
        op.push  = wr_en & ~is_full  & ~op.clear;
        op.pop   = rd_en & ~is_empty & ~op.clear;
    end

    assign ovf = wr_en & is_full & ~op.clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_SINGLE;
            depth_q <= DEPTH_ONE;
            count_q <= '0;
        end else if (op.clear) begin
            mode_q  <= mode_new;
            count_q <= '0;
            if (mode_chg) begin
                depth_q <= (mode_new == MODE_DEEP) ? DEPTH_DEEP : DEPTH_ONE;
            end else begin
                depth_q <= DEPTH_DEEP;
            end
        end else begin
            unique case ({op.push, op.pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign depth     = depth_q;
    assign count     = count_q;
    assign not_empty = ~is_empty;
    assign full      = is_full;

    // R6: occupancy never exceeds the active depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= depth_q);

    // R6: a lone write into a full block is refused
    a_r6_refused: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && is_full && !flush && !mode_chg) |=> $stable(count_q));

    // R4: a mode change leaves the block empty with the matching depth
    a_r4_mode_clear: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && deep_sel) |=> (count_q == '0 && depth_q == DEPTH_DEEP));

    a_r4_mode_clear_single: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && !deep_sel) |=> (count_q == '0 && depth_q == DEPTH_ONE));

    // R5: flush without a mode change empties and selects the full depth
    a_r5_flush: assert property (@(posedge clk) disable iff (rst)
        (flush && !mode_chg) |=> (count_q == '0 && depth_q == DEPTH_DEEP));

    // R7: a read from a full block releases backpressure
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_full && !flush && !mode_chg) |=> !is_full);

    // R9: a lone read from an empty block changes nothing
    a_r9_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && is_empty && !flush && !mode_chg) |=> (count_q == '0));

    // R10: concurrent strobes on a partly filled block hold the occupancy
    a_r10_rw_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && !is_empty && !is_full && !flush && !mode_chg)
            |=> $stable(count_q));

endmodule

// File: rtl/rxq_switchable_fifo.sv
// Receive byte queue whose depth is 1 or DEPTH, chosen at run time.
module rxq_switchable_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = RXQ_DATA_W,
    parameter int DEPTH  = RXQ_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_sel,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ovf,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              not_empty,
    output logic              full
);

    localparam logic [DATA_W-1:0] EMPTY_BYTE = '1;

    rxq_op_t           op;
    logic [CNT_W-1:0]  depth;
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [DATA_W-1:0] head;

    rxq_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .deep_sel  (deep_sel),
        .flush     (flush),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .op        (op),
        .ovf       (ovf),
        .depth     (depth),
        .count     (count),
        .not_empty (not_empty),
        .full      (full)
    );

    rxq_ptr #(
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) i_wptr (
        .clk (clk),
        .rst (rst),
        .clr (op.clear),
        .adv (op.push),
        .lim (depth),
        .ptr (wptr)
    );

    rxq_ptr #(
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) i_rptr (
        .clk (clk),
        .rst (rst),
        .clr (op.clear),
        .adv (op.pop),
        .lim (depth),
        .ptr (rptr)
    );

    rxq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) i_store (
        .clk   (clk),
        .we    (op.push),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (head)
    );

    assign rd_data = not_empty ? head : EMPTY_BYTE;

    // R11: the flag tracks a nonzero occupancy
    a_r11_not_empty: assert property (@(posedge clk) disable iff (rst)
        not_empty == (count != '0));

    // R9: an empty block presents the all-ones byte
    a_r9_empty_value: assert property (@(posedge clk) disable iff (rst)
        !not_empty |-> (rd_data == EMPTY_BYTE));

    // R2: a write accepted into an empty single-slot block fills it
    a_r2_single_fill: assert property (@(posedge clk) disable iff (rst)
        (op.push && !op.pop && depth == CNT_W'(1)) |=> full);

endmodule

// File: tb/test_rxq_switchable_fifo.sv
`timescale 1ns/1ps
module test_rxq_switchable_fifo;

    logic       clk = 1'b0;
    logic       rst;
    logic       deep_sel, flush, wr_en, rd_en;
    logic [7:0] wr_data;
    logic       ovf;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic       not_empty, full;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [7:0] mq[$];
    int         m_depth;
    int         m_mode;

    always #2 clk = ~clk;   // 250 MHz

    rxq_switchable_fifo i_rxq_switchable_fifo (
        .clk       (clk),
        .rst       (rst),
        .deep_sel  (deep_sel),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ovf       (ovf),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .count     (count),
        .not_empty (not_empty),
        .full      (full)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One cycle: drive at falling edge, compare, then update the model at the rising edge.
    task automatic step(input string tag, input logic dm, input logic fl,
                        input logic w, input logic [7:0] wd, input logic r);
        logic clr;
        int   sz;
        @(negedge clk);
        deep_sel = dm; flush = fl; wr_en = w; wr_data = wd; rd_en = r;
        #1;
        sz  = mq.size();
        clr = fl || (int'(dm) != m_mode);
        chk(tag, "count", int'(count), sz);
        chk(tag, "not_empty R11", int'(not_empty), int'(sz != 0));
        chk(tag, "full R7", int'(full), int'(sz == m_depth));
        chk(tag, "rd_data R9", int'(rd_data), (sz != 0) ? int'(mq[0]) : 255);
        chk(tag, "ovf R6", int'(ovf), int'(w && !clr && sz == m_depth));
        @(posedge clk);
        if (clr) begin
            mq.delete();
            if (int'(dm) != m_mode) m_depth = dm ? 16 : 1;
            else                    m_depth = 16;
            m_mode = int'(dm);
        end else begin
            if (r && sz > 0)       void'(mq.pop_front());
            if (w && sz < m_depth) mq.push_back(wd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; deep_sel = 0; flush = 0; wr_en = 0; rd_en = 0; wr_data = 0;
        m_depth = 1; m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        step("R1", 0, 0, 0, 8'h00, 0);

        // R2 single holding register
        step("R2", 0, 0, 1, 8'h11, 0);
        step("R2", 0, 0, 0, 8'h00, 0);
        step("R6", 0, 0, 1, 8'h22, 0);          // refused
        step("R10", 0, 0, 1, 8'h33, 1);         // full: read only, write refused
        step("R9", 0, 0, 0, 8'h00, 1);          // empty read
        step("R10", 0, 0, 1, 8'h44, 1);         // empty: write only
        step("R7", 0, 0, 0, 8'h00, 1);

        // R4 mode change to deep with a write offered (ignored)
        step("R4", 0, 0, 1, 8'h55, 0);
        step("R4", 1, 0, 1, 8'h66, 0);
        step("R4", 1, 0, 0, 8'h00, 0);

        // R3 fill 16, R6 refuse the 17th
        for (int i = 0; i < 16; i++) step("R3", 1, 0, 1, 8'(8'hA0 + i), 0);
        step("R6", 1, 0, 1, 8'hEE, 0);
        step("R7", 1, 0, 0, 8'h00, 1);
        step("R8", 1, 0, 1, 8'hB0, 0);          // write wraps to slot 0
        for (int i = 0; i < 18; i++) step("R8", 1, 0, 0, 8'h00, 1);

        // R10 concurrent strobes on partly filled queue
        for (int i = 0; i < 3; i++) step("R10", 1, 0, 1, 8'(8'hC0 + i), 0);
        for (int i = 0; i < 20; i++) step("R10", 1, 0, 1, 8'(8'hD0 + i), 1);

        // R5 flush in deep mode
        step("R5", 1, 1, 1, 8'h77, 1);
        step("R5", 1, 0, 1, 8'h78, 0);

        // R4 switch to single while holding data
        step("R4", 0, 0, 0, 8'h00, 0);
        step("R4", 0, 0, 1, 8'h79, 0);
        // R5 flush in single mode selects 16
        step("R5", 0, 1, 0, 8'h00, 0);
        for (int i = 0; i < 4; i++) step("R5", 0, 0, 1, 8'(8'h80 + i), 0);
        // R5 flush together with a mode change: depth follows mode
        step("R5", 1, 1, 0, 8'h00, 0);
        for (int i = 0; i < 3; i++) step("R5", 1, 0, 1, 8'(8'h90 + i), 0);
        step("R4", 0, 1, 0, 8'h00, 0);
        step("R4", 0, 0, 1, 8'h9A, 0);
        step("R4", 0, 0, 1, 8'h9B, 0);

        // R3 pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] rnd;
            rnd = 8'($urandom);
            step("R3", (i % 97) < 80, rnd[7:5] == 3'd0 && rnd[4],
                 rnd[0] | rnd[1], 8'($urandom), rnd[2] & rnd[3]);
        end

        summary();
        $finish;
    end

endmodule